// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move bytes between a narrow data port and a small local packet memory without addressing each byte itself. The host programs a 16-bit remote address and a 16-bit remote byte count through an 8-bit register interface, one byte at a time. Every access on the data port then reads or writes 1, 2 or 4 bytes at the current address. After each access the address moves on, wrapping inside a ring of 256-byte pages, and the count runs down. When the count is used up, a completion status bit is raised and can drive an interrupt line.

The local memory is a sparse window. A small region at the bottom of the address space and a larger region starting at a configurable base can be accessed. Writes anywhere else are dropped, and reads anywhere else return all ones. Multi-byte accesses are little-endian and start at an even address. A control write that asks for a remote transfer while the count is already zero completes at once. This serves drivers that start zero-length transfers.

Top module: `rdma_engine`

## Requirements
- R1: After reset the control register reads 0x01, the address, count, ring pages, width setting, status and mask all read 0, and `irq` is low.
- R2: Register offsets are: 0 control, 1/2 address low/high byte, 3/4 count low/high byte, 5 ring first page, 6 ring end page, 7 width setting (bit 0), 8 status, 9 mask. Each byte of the address and count is written and read back separately.
- R3: A data-port access moves 4 bytes when `port_dword` is high. Otherwise it moves 2 bytes when width bit 0 is set, and 1 byte when it is clear. The address then increases by that size.
- R4: If the increased address equals the ring end page times 256, the address is reloaded with the ring first page times 256.
- R5: If the count is less than or equal to the access size, the count becomes 0 and status bit 6 (transfer complete) is set. Otherwise the count decreases by the access size.
- R6: A data-port write while the count is 0 changes neither memory, address nor count.
- R7: A data-port read is performed whatever the count. With a count of 0 it still advances the address and sets status bit 6.
- R8: A control write with bit 0 (halt) clear, bit 1 (remote read) or bit 2 (remote write) set, and a count of 0 sets status bit 6 on the same edge. With halt set, or a nonzero count, it does not.
- R9: A 2- or 4-byte access clears address bit 0 for the memory lanes. Byte k of the port data maps to memory address base+k.
- R10: Memory byte addresses below LOW_SIZE, or in [WIN_BASE, WIN_BASE+WIN_SIZE), are backed by storage. Each byte lane outside them drops writes and reads as 0xFF. Unused read lanes return 0.
- R11: `irq` is high exactly when status AND mask AND 0x7F is nonzero. Writing a 1 to a status bit (6..0) clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at `reg_addr` (combinational) |
| port_wr | input | 1 | Data-port write access |
| port_rd | input | 1 | Data-port read access |
| port_dword | input | 1 | Access is 4 bytes wide |
| port_wdata | input | 32 | Data-port write data, byte 0 in bits 7:0 |
| port_rdata | output | 32 | Data-port read data at the current address (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with its default parameters: a 16-bit address and count, a 32-byte low region, and a 1 KB window at 16 KB. This size keeps the memory small, but it still places both window edges, the gap between the regions and a ring of one page within reach of directed addresses. A 4-byte read at the top of the low region straddles backed and unbacked lanes. A ring whose end page is just above the start of the window makes the reload visible after a single 2-byte write.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

   // Register offsets on the 8-bit host interface
   localparam logic [3:0] REG_CTRL   = 4'd0;
   localparam logic [3:0] REG_ADR_LO = 4'd1;
   localparam logic [3:0] REG_ADR_HI = 4'd2;
   localparam logic [3:0] REG_CNT_LO = 4'd3;
   localparam logic [3:0] REG_CNT_HI = 4'd4;
   localparam logic [3:0] REG_RING_F = 4'd5;
   localparam logic [3:0] REG_RING_E = 4'd6;
   localparam logic [3:0] REG_WIDTH  = 4'd7;
   localparam logic [3:0] REG_STAT   = 4'd8;
   localparam logic [3:0] REG_MASK   = 4'd9;

   // Control bit positions
   localparam int CTL_HALT = 0;
   localparam int CTL_RREQ = 1;
   localparam int CTL_WREQ = 2;

   // Status bit raised at transfer end
   localparam int ST_DONE = 6;

   localparam logic [7:0] CTRL_RST = 8'h01;

   // Bytes moved by one access
   typedef enum logic [2:0] {
      XFER_1 = 3'd1,
      XFER_2 = 3'd2,
      XFER_4 = 3'd4
   } xfer_e;

   localparam int PORT_BYTES = 4;

endpackage

// File: rtl/rdma_step.sv
module rdma_step
   import rdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   localparam int PG_W  = ADDR_W - 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [PG_W-1:0]   first_pg,
   input  logic [PG_W-1:0]   end_pg,
   input  logic              wide16,
   input  logic              dword,
   output xfer_e             size,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic [CNT_W-1:0]  nxt_cnt,
   output logic              done
);

   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] stop_a;
   logic [ADDR_W-1:0] reload_a;
   logic [CNT_W-1:0]  size_c;

   always_comb begin
      if (dword)       size = XFER_4;
      else if (wide16) size = XFER_2;
      else             size = XFER_1;
   end

   // Lane base: even for multi-byte accesses
   assign base     = (size == XFER_1) ? addr : {addr[ADDR_W-1:1], 1'b0};

   assign sum      = addr + ADDR_W'(size);
   assign stop_a   = {end_pg, 8'h00};
   assign reload_a = {first_pg, 8'h00};
   assign nxt_addr = (sum == stop_a) ? reload_a : sum;

   assign size_c   = CNT_W'(size);
   assign done     = (cnt <= size_c);
   assign nxt_cnt  = done ? '0 : (cnt - size_c);

endmodule

// File: rtl/rdma_localmem.sv
module rdma_localmem
   import rdma_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int LOW_SIZE = 32,
   parameter int WIN_BASE = 16384,
   parameter int WIN_SIZE = 1024,
   localparam int DEPTH   = LOW_SIZE + WIN_SIZE,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] base,
   input  xfer_e             size,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata
);

   localparam logic [ADDR_W:0] LOW_LIM = (ADDR_W+1)'(LOW_SIZE);
   localparam logic [ADDR_W:0] WIN_LO  = (ADDR_W+1)'(WIN_BASE);
   localparam logic [ADDR_W:0] WIN_HI  = (ADDR_W+1)'(WIN_BASE + WIN_SIZE);
   localparam logic [ADDR_W:0] WIN_OFF = (ADDR_W+1)'(WIN_BASE - LOW_SIZE);

   logic [7:0]       mem [DEPTH];
   logic [IDX_W-1:0] lane_idx [PORT_BYTES];
   logic             lane_hit [PORT_BYTES];
   logic             lane_use [PORT_BYTES];

   for (genvar i = 0; i < PORT_BYTES; i++) begin : g_lane
      logic [ADDR_W:0] la;
      logic            in_low;
      logic            in_win;

      assign la     = {1'b0, base + ADDR_W'(i)};
      assign in_low = (la < LOW_LIM);
      assign in_win = (la >= WIN_LO) && (la < WIN_HI);
      assign lane_hit[i] = in_low | in_win;
      assign lane_use[i] = (3'(i) < size);
      assign lane_idx[i] = in_low ? IDX_W'(la) : IDX_W'(la - WIN_OFF);

      always_comb begin
         if (!lane_use[i])     rdata[8*i +: 8] = 8'h00;
         else if (lane_hit[i]) rdata[8*i +: 8] = mem[lane_idx[i]];
         else                  rdata[8*i +: 8] = 8'hFF;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < PORT_BYTES; i++) begin
         if (wr_en && lane_use[i] && lane_hit[i])
            mem[lane_idx[i]] <= wdata[8*i +: 8];
      end
   end

endmodule

// File: rtl/rdma_regs.sv
module rdma_regs
   import rdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   localparam int PG_W  = ADDR_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              step_en,
   input  logic [ADDR_W-1:0] nxt_addr,
   input  logic [CNT_W-1:0]  nxt_cnt,
   input  logic              step_done,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [PG_W-1:0]   first_pg,
   output logic [PG_W-1:0]   end_pg,
   output logic              wide16,
   output logic [7:0]        status_q,
   output logic [7:0]        mask_q
);

   logic [7:0] ctrl_q;
   logic       zero_start;
   logic       set_done;
   logic [7:0] status_n;

   assign zero_start = reg_wr && (reg_addr == REG_CTRL)
                       && !reg_wdata[CTL_HALT]
                       && (reg_wdata[CTL_RREQ] || reg_wdata[CTL_WREQ])
                       && (cnt_q == '0);
   assign set_done   = (step_en && step_done) || zero_start;

   always_comb begin
      status_n = status_q;
      if (reg_wr && reg_addr == REG_STAT)
         status_n = status_q & ~(reg_wdata & 8'h7F);
      if (set_done)
         status_n[ST_DONE] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RST;
         addr_q   <= '0;
         cnt_q    <= '0;
         first_pg <= '0;
         end_pg   <= '0;
         wide16   <= 1'b0;
         status_q <= '0;
         mask_q   <= '0;
      end else begin
         status_q <= status_n;
         if (step_en) begin
            addr_q <= nxt_addr;
            cnt_q  <= nxt_cnt;
         end
         if (reg_wr) begin
            unique case (reg_addr)
               REG_CTRL:   ctrl_q              <= reg_wdata;
               REG_ADR_LO: addr_q[7:0]         <= reg_wdata;
               REG_ADR_HI: addr_q[ADDR_W-1:8]  <= reg_wdata[ADDR_W-9:0];
               REG_CNT_LO: cnt_q[7:0]          <= reg_wdata;
               REG_CNT_HI: cnt_q[CNT_W-1:8]    <= reg_wdata[CNT_W-9:0];
               REG_RING_F: first_pg            <= reg_wdata[PG_W-1:0];
               REG_RING_E: end_pg              <= reg_wdata[PG_W-1:0];
               REG_WIDTH:  wide16              <= reg_wdata[0];
               REG_MASK:   mask_q              <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (reg_addr)
         REG_CTRL:   reg_rdata = ctrl_q;
         REG_ADR_LO: reg_rdata = addr_q[7:0];
         REG_ADR_HI: reg_rdata = 8'(addr_q[ADDR_W-1:8]);
         REG_CNT_LO: reg_rdata = cnt_q[7:0];
         REG_CNT_HI: reg_rdata = 8'(cnt_q[CNT_W-1:8]);
         REG_RING_F: reg_rdata = 8'(first_pg);
         REG_RING_E: reg_rdata = 8'(end_pg);
         REG_WIDTH:  reg_rdata = {7'd0, wide16};
         REG_STAT:   reg_rdata = status_q;
         REG_MASK:   reg_rdata = mask_q;
         default:    reg_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
   import rdma_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int CNT_W    = 16,
   parameter int LOW_SIZE = 32,
   parameter int WIN_BASE = 16384,
   parameter int WIN_SIZE = 1024
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [3:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        port_wr,
   input  logic        port_rd,
   input  logic        port_dword,
   input  logic [31:0] port_wdata,
   output logic [31:0] port_rdata,
   output logic        irq
);

   localparam int PG_W = ADDR_W - 8;

   // Elaboration-time parameter checks
   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
      $error("rdma_engine: ADDR_W must lie in 9..16");
   end
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
      $error("rdma_engine: CNT_W must lie in 9..16");
   end
   if (LOW_SIZE < 1 || LOW_SIZE > WIN_BASE) begin : g_bad_low
      $error("rdma_engine: LOW_SIZE must be 1..WIN_BASE");
   end
   if (WIN_SIZE < 1 || WIN_BASE + WIN_SIZE > (1 << ADDR_W)) begin : g_bad_win
      $error("rdma_engine: window must fit in the address space");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PG_W-1:0]   first_pg;
   logic [PG_W-1:0]   end_pg;
   logic              wide16;
   logic [7:0]        status_q;
   logic [7:0]        mask_q;
   xfer_e             xfer_size;
   logic [ADDR_W-1:0] lane_base;
   logic [ADDR_W-1:0] nxt_addr;
   logic [CNT_W-1:0]  nxt_cnt;
   logic              step_done;
   logic              wr_live;
   logic              step_en;

   assign wr_live = port_wr && (cnt_q != '0);
   assign step_en = port_rd || wr_live;

   rdma_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
      .addr     (addr_q),
      .cnt      (cnt_q),
      .first_pg (first_pg),
      .end_pg   (end_pg),
      .wide16   (wide16),
      .dword    (port_dword),
      .size     (xfer_size),
      .base     (lane_base),
      .nxt_addr (nxt_addr),
      .nxt_cnt  (nxt_cnt),
      .done     (step_done)
   );

   rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .step_en   (step_en),
      .nxt_addr  (nxt_addr),
      .nxt_cnt   (nxt_cnt),
      .step_done (step_done),
      .addr_q    (addr_q),
      .cnt_q     (cnt_q),
      .first_pg  (first_pg),
      .end_pg    (end_pg),
      .wide16    (wide16),
      .status_q  (status_q),
      .mask_q    (mask_q)
   );

   rdma_localmem #(
      .ADDR_W   (ADDR_W),
      .LOW_SIZE (LOW_SIZE),
      .WIN_BASE (WIN_BASE),
      .WIN_SIZE (WIN_SIZE)
   ) u_mem (
      .clk   (clk),
      .base  (lane_base),
      .size  (xfer_size),
      .wr_en (wr_live && !port_rd),
      .wdata (port_wdata),
      .rdata (port_rdata)
   );

   assign irq = |(status_q & mask_q & 8'h7F);

endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk
   import rdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   localparam int PG_W  = ADDR_W - 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [3:0]        reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              port_wr,
   input logic              port_rd,
   input logic              step_en,
   input xfer_e             size,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  cnt,
   input logic [PG_W-1:0]   first_pg,
   input logic [PG_W-1:0]   end_pg,
   input logic [7:0]        status,
   input logic [7:0]        mask,
   input logic              irq
);

   assert_wrap_skips_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !reg_wr && end_pg != first_pg) |=> (addr != {$past(end_pg), 8'h00}));

   assert_last_access_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !reg_wr && cnt != '0 && cnt <= CNT_W'(size))
      |=> (cnt == '0 && status[ST_DONE]));

   assert_count_runs_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !reg_wr && cnt > CNT_W'(size))
      |=> (cnt == $past(cnt) - CNT_W'($past(size))));

   assert_empty_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && !port_rd && !reg_wr && cnt == '0) |=> ($stable(addr) && cnt == '0));

   assert_read_at_zero_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rd && !reg_wr && cnt == '0) |=> status[ST_DONE]);

   assert_zero_start_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_CTRL && !reg_wdata[CTL_HALT]
       && (reg_wdata[CTL_RREQ] || reg_wdata[CTL_WREQ]) && cnt == '0)
      |=> status[ST_DONE]);

   assert_masked_done_raises_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_DONE] && mask[ST_DONE]) |-> irq);

   assert_no_mask_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 8'h00) |-> !irq);

endmodule

bind rdma_engine rdma_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .port_wr   (port_wr),
   .port_rd   (port_rd),
   .step_en   (step_en),
   .size      (xfer_size),
   .addr      (addr_q),
   .cnt       (cnt_q),
   .first_pg  (first_pg),
   .end_pg    (end_pg),
   .status    (status_q),
   .mask      (mask_q),
   .irq       (irq)
);

// File: tb/rdma_engine_tb.sv
`timescale 1ns/1ps
module rdma_engine_tb;

   localparam logic [3:0] O_CTRL = 4'd0, O_ALO = 4'd1, O_AHI = 4'd2,
                          O_CLO = 4'd3, O_CHI = 4'd4, O_RF = 4'd5,
                          O_RE = 4'd6, O_WID = 4'd7, O_ST = 4'd8, O_MSK = 4'd9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        port_wr = 1'b0;
   logic        port_rd = 1'b0;
   logic        port_dword = 1'b0;
   logic [31:0] port_wdata = 32'd0;
   logic [31:0] port_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rdma_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_wr(port_wr),
      .port_rd(port_rd), .port_dword(port_dword), .port_wdata(port_wdata),
      .port_rdata(port_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_addr(input logic [15:0] a);
      wr_reg(O_ALO, a[7:0]); wr_reg(O_AHI, a[15:8]);
   endtask

   task automatic set_cnt(input logic [15:0] c);
      wr_reg(O_CLO, c[7:0]); wr_reg(O_CHI, c[15:8]);
   endtask

   task automatic get_addr(output logic [15:0] a);
      logic [7:0] lo, hi;
      rd_reg(O_ALO, lo); rd_reg(O_AHI, hi);
      a = {hi, lo};
   endtask

   task automatic get_cnt(output logic [15:0] c);
      logic [7:0] lo, hi;
      rd_reg(O_CLO, lo); rd_reg(O_CHI, hi);
      c = {hi, lo};
   endtask

   task automatic xfer(input bit rd, input bit dw, input logic [31:0] wd,
                       output logic [31:0] rv);
      @(negedge clk);
      port_rd = rd; port_wr = !rd; port_dword = dw; port_wdata = wd;
      #1 rv = port_rdata;
      @(posedge clk); #1;
      port_rd = 1'b0; port_wr = 1'b0; port_dword = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      logic [15:0] w;
      rd_reg(O_CTRL, v); check("R1 ctrl", v, 8'h01);
      get_addr(w);       check("R1 addr", w, 16'h0);
      get_cnt(w);        check("R1 count", w, 16'h0);
      rd_reg(O_ST, v);   check("R1 status", v, 8'h00);
      rd_reg(O_MSK, v);  check("R1 mask", v, 8'h00);
      check("R1 irq", irq, 1'b0);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      wr_reg(O_ALO, 8'h34); wr_reg(O_AHI, 8'h12);
      rd_reg(O_ALO, v); check("R2 addr lo", v, 8'h34);
      rd_reg(O_AHI, v); check("R2 addr hi", v, 8'h12);
      wr_reg(O_CHI, 8'h56); wr_reg(O_CLO, 8'h78);
      rd_reg(O_CLO, v); check("R2 cnt lo", v, 8'h78);
      rd_reg(O_CHI, v); check("R2 cnt hi", v, 8'h56);
   endtask

   task automatic t_bytes_irq;
      logic [31:0] r;
      logic [15:0] w;
      logic [7:0] v;
      wr_reg(O_WID, 8'h00);
      set_addr(16'h4000); set_cnt(16'd3);
      xfer(0, 0, 32'hAA, r); xfer(0, 0, 32'hBB, r);
      get_cnt(w);  check("R5 count after 2 of 3", w, 16'd1);
      rd_reg(O_ST, v); check("R5 not done yet", v, 8'h00);
      xfer(0, 0, 32'hCC, r);
      get_addr(w); check("R3 byte advance", w, 16'h4003);
      get_cnt(w);  check("R5 count zero", w, 16'd0);
      rd_reg(O_ST, v); check("R5 done bit", v, 8'h40);
      check("R11 irq masked off", irq, 1'b0);
      wr_reg(O_MSK, 8'h40);
      @(negedge clk); #1 check("R11 irq on", irq, 1'b1);
      wr_reg(O_ST, 8'h40);
      rd_reg(O_ST, v); check("R11 w1c status", v, 8'h00);
      check("R11 irq off", irq, 1'b0);
      set_addr(16'h4000); set_cnt(16'd3);
      xfer(1, 0, 0, r); check("R3 read b0", r, 32'hAA);
      xfer(1, 0, 0, r); check("R3 read b1", r, 32'hBB);
      xfer(1, 0, 0, r); check("R3 read b2", r, 32'hCC);
      @(negedge clk); #1 check("R11 irq after read done", irq, 1'b1);
      wr_reg(O_ST, 8'h7F); wr_reg(O_MSK, 8'h00);
   endtask

   task automatic t_wide;
      logic [31:0] r;
      logic [15:0] w;
      wr_reg(O_WID, 8'h01);
      set_addr(16'h4011); set_cnt(16'd4);
      xfer(0, 0, 32'h1234, r);
      get_addr(w); check("R3 word advance", w, 16'h4013);
      get_cnt(w);  check("R5 count minus 2", w, 16'd2);
      xfer(0, 0, 32'h5678, r);
      get_cnt(w);  check("R5 count equal size", w, 16'd0);
      wr_reg(O_WID, 8'h00);
      set_addr(16'h4010); set_cnt(16'd8);
      xfer(1, 0, 0, r); check("R9 le byte0", r, 32'h34);
      xfer(1, 0, 0, r); check("R9 le byte1", r, 32'h12);
      xfer(1, 0, 0, r); check("R9 le byte2", r, 32'h78);
      set_addr(16'h4011);
      xfer(1, 1, 0, r); check("R9 dword aligned read", r, 32'h5678_1234);
      get_addr(w); check("R3 dword advance", w, 16'h4015);
      wr_reg(O_ST, 8'h7F);
   endtask

   task automatic t_wrap;
      logic [31:0] r;
      logic [15:0] w;
      wr_reg(O_RF, 8'h40); wr_reg(O_RE, 8'h41); wr_reg(O_WID, 8'h01);
      set_addr(16'h40FE); set_cnt(16'd10);
      xfer(0, 0, 32'h0000_BEEF, r);
      get_addr(w); check("R4 wrap to first page", w, 16'h4000);
      get_cnt(w);  check("R5 count after wrap", w, 16'd8);
      set_addr(16'h40FC);
      xfer(0, 0, 32'h0, r);
      get_addr(w); check("R4 no wrap before stop", w, 16'h40FE);
      wr_reg(O_RE, 8'h00); wr_reg(O_RF, 8'h00); wr_reg(O_WID, 8'h00);
   endtask

   task automatic t_zero_write;
      logic [31:0] r;
      logic [15:0] w;
      set_addr(16'h4020); set_cnt(16'd1);
      xfer(0, 0, 32'h11, r);
      wr_reg(O_ST, 8'h7F);
      xfer(0, 0, 32'h99, r);
      get_addr(w); check("R6 addr held", w, 16'h4021);
      get_cnt(w);  check("R6 count held", w, 16'd0);
      set_addr(16'h4020); set_cnt(16'd1);
      xfer(1, 0, 0, r); check("R6 memory unchanged", r, 32'h11);
      set_addr(16'h4021); set_cnt(16'd0);
      xfer(0, 0, 32'h77, r);
      set_cnt(16'd1);
      set_addr(16'h4021);
      xfer(1, 0, 0, r); check("R6 next byte not written", r === 32'h77 ? 32'h1 : 32'h0, 32'h0);
      wr_reg(O_ST, 8'h7F);
   endtask

   task automatic t_zero_read;
      logic [31:0] r;
      logic [15:0] w;
      logic [7:0] v;
      set_addr(16'h4030); set_cnt(16'd0);
      xfer(1, 0, 0, r);
      get_addr(w); check("R7 read advances at zero", w, 16'h4031);
      rd_reg(O_ST, v); check("R7 done at zero", v, 8'h40);
      wr_reg(O_ST, 8'h7F);
   endtask

   task automatic t_zero_start;
      logic [7:0] v;
      set_cnt(16'd0);
      wr_reg(O_CTRL, 8'h02);
      rd_reg(O_ST, v); check("R8 read start zero", v, 8'h40);
      wr_reg(O_ST, 8'h40);
      wr_reg(O_CTRL, 8'h04);
      rd_reg(O_ST, v); check("R8 write start zero", v, 8'h40);
      wr_reg(O_ST, 8'h40);
      wr_reg(O_CTRL, 8'h03);
      rd_reg(O_ST, v); check("R8 halt blocks", v, 8'h00);
      set_cnt(16'd5);
      wr_reg(O_CTRL, 8'h02);
      rd_reg(O_ST, v); check("R8 nonzero count", v, 8'h00);
      rd_reg(O_CTRL, v); check("R2 ctrl readback", v, 8'h02);
   endtask

   task automatic t_window;
      logic [31:0] r;
      set_cnt(16'd100);
      set_addr(16'h0100);
      xfer(1, 0, 0, r); check("R10 gap byte", r, 32'hFF);
      set_addr(16'h0100);
      xfer(0, 0, 32'h12, r);
      set_addr(16'h0100);
      xfer(1, 1, 0, r); check("R10 gap dword", r, 32'hFFFF_FFFF);
      set_addr(16'h0004);
      xfer(0, 0, 32'h5A, r);
      set_addr(16'h0004);
      xfer(1, 0, 0, r); check("R10 low region", r, 32'h5A);
      set_addr(16'h001E);
      xfer(0, 0, 32'h11, r); xfer(0, 0, 32'h22, r);
      set_addr(16'h001E);
      xfer(1, 1, 0, r); check("R10 straddle low edge", r, 32'hFFFF_2211);
      set_addr(16'h43FF);
      xfer(0, 0, 32'hC3, r);
      set_addr(16'h43FF);
      xfer(1, 0, 0, r); check("R10 window top byte", r, 32'hC3);
      set_addr(16'h4400);
      xfer(1, 0, 0, r); check("R10 above window", r, 32'hFF);
      set_addr(16'h3FFF);
      xfer(1, 0, 0, r); check("R10 below window", r, 32'hFF);
      wr_reg(O_ST, 8'h7F);
   endtask

   initial begin
      #200_000;
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regs();
      t_bytes_irq();
      t_wide();
      t_wrap();
      t_zero_write();
      t_zero_read();
      t_zero_start();
      t_window();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule